// File: doc/BRIEF.md
# Multi-Device Clock and NCO Synchronizer

This block lives in the digital datapath of a converter and brings several identical devices into lockstep in two ordered steps. First, an external sync line is sampled by the full-rate converter clock. Its rising edge forces the internal rate divider to a known phase. Every device that sees the same edge in the same fast-clock period then produces its data-rate clock enable on the same fast-clock edge. The sync line may carry one pulse or a periodic train. A periodic train whose spacing is a whole multiple of the divide ratio finds the divider already at the target phase. Such a pulse is then only counted and does not disturb anything.

Second, once the dividers agree, a transmit-enable strobe shared by all devices clears the numerically controlled oscillator's phase accumulator. The strobe is sampled only on data-rate enables, the same way input samples are. By default the strobe is a low-going pulse on an otherwise high line. A configuration bit flips it to a high-going pulse. Between clears, the accumulator adds a frequency tuning word on every data-rate enable. A sticky flag reports that both steps have taken place since reset.

Top module: `dac_sync_top`

## Requirements
- R1: The sync line passes through two synchronizer flops. If it is first sampled high at fast-clock edge k, the divider holds phase 0 after edge k+2. `data_en` is then high in the cycles that follow edges k+2+(ratio−1)+j·ratio, for j = 0, 1, 2, ….
- R2: The divide ratio is 2^`div_sel`, and `div_sel` values above 4 act as 4. `data_en` is a one-cycle pulse every ratio cycles. At ratio 1 it is high in every cycle.
- R3: Only a low-to-high transition of the synchronized sync line is an event. A sync level held high for many cycles acts once.
- R4: Take a sync event that finds the divider at its last phase (ratio−1), so that the next phase would be 0 anyway. Such an event does not disturb the `data_en` pattern. It increments `aligned_cnt`.
- R5: A sync event at any other phase reloads the divider as in R1. It leaves `aligned_cnt` unchanged.
- R6: `aligned_cnt` is 4 bits wide and saturates at 15.
- R7: The strobe's asserted level is low when `txen_invert` is 0 and high when it is 1. The strobe line is sampled only on edges where `data_en` is high. A strobe is detected when the sampled level changes from deasserted to asserted. After reset, the previous sampled level counts as asserted, so a line that is already asserted at reset is not a strobe.
- R8: On the enable edge that detects a strobe, the phase still advances by `ftw`. On the next enable edge the phase becomes 0. On the enable edge after that, the phase becomes `ftw`.
- R9: Apart from a clear, `nco_phase` grows by `ftw` modulo 2^16 on every enable edge. It holds its value on all other edges.
- R10: A transition from asserted to deasserted, and an asserted level that is simply held, never clear the phase.
- R11: `sync_done` rises once at least one sync event and at least one phase clear have both occurred. It then stays high until reset.
- R12: Synchronous active-low reset sets the phase to 0, `aligned_cnt` to 0, `sync_done` to 0 and the divider to phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate converter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_in | input | 1 | External divider sync line (asynchronous) |
| txen_in | input | 1 | Transmit-enable strobe line |
| txen_invert | input | 1 | 0: strobe is low-going; 1: strobe is high-going |
| div_sel | input | 3 | log2 of the divide ratio (0..4) |
| ftw | input | 16 | Frequency tuning word |
| data_en | output | 1 | Data-rate clock enable |
| nco_phase | output | 16 | Phase accumulator value |
| aligned_cnt | output | 4 | Saturating count of sync events that arrived already aligned |
| sync_done | output | 1 | Both synchronization steps have occurred since reset |

## Verification
A sync level driven at a falling edge reaches the divider three rising edges later. From that point, `data_en` is predicted by modular arithmetic on the count of falling edges since the drive, with ratio−1 added for the first pulse. The bench therefore samples every falling edge and compares each one against that formula, including the two cycles before a misaligned reload takes effect. A strobe change is sampled on the next enable edge and zeroes the phase one enable edge later. The bench steps from enable to enable by watching `data_en` and reads the phase one falling edge after each enable edge, against sums of `ftw` truncated to 16 bits.

// File: rtl/dac_sync_pkg.sv
// Package: shared types for the multi-device synchronizer.
// Assumes: nothing; holds the strobe polarity encoding only.
package dac_sync_pkg;
    // Polarity of the transmit-enable strobe as selected by the invert bit.
    typedef enum logic {
        STROBE_LOW_GOING  = 1'b0,
        STROBE_HIGH_GOING = 1'b1
    } strobe_pol_e;
endpackage

// File: rtl/sync_rise_det.sv
// Module: sync_rise_det
// Brings an asynchronous line into the fast clock domain through STAGES
// flops and flags a single-cycle pulse on each low-to-high transition.
// Assumes: the input level is held for at least two fast-clock cycles.
module sync_rise_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_o
);
    logic [STAGES:0] shift_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], async_in};
    end

    // Rising edge of the synchronized level.
    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/rate_divider.sv
// Module: rate_divider
// Counts fast-clock cycles modulo 2^div_sel, and emits data_en on the last
// phase. A sync event forces phase 0 unless the counter is about to reach
// it anyway; such aligned events are counted in a saturating counter.
// Assumes: SEL_W is wide enough to hold DIV_W.
module rate_divider #(
    parameter int DIV_W  = 4,
    parameter int SEL_W  = 3,
    parameter int ACNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_rise,
    input  logic [SEL_W-1:0]  div_sel,
    output logic              data_en,
    output logic              div_synced,
    output logic [ACNT_W-1:0] aligned_cnt
);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(DIV_W);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] mask;
    logic [SEL_W-1:0] sel_c;
    logic             at_end;

    // Clamp the ratio selection and build the phase mask.
    always_comb begin
        sel_c  = (div_sel > SEL_MAX) ? SEL_MAX : div_sel;
        mask   = {DIV_W{1'b1}} >> (SEL_MAX - sel_c);
        at_end = ((cnt_q & mask) == mask);
    end

    assign data_en = at_end;

    // Phase counter: reload on a misaligned sync, otherwise wrap on the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (sync_rise && !at_end) cnt_q <= '0;
        else                          cnt_q <= (cnt_q + DIV_W'(1)) & mask;
    end

    // Saturating tally of sync events that found the divider aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aligned_cnt <= '0;
        else if (sync_rise && at_end && (aligned_cnt != {ACNT_W{1'b1}}))
            aligned_cnt <= aligned_cnt + ACNT_W'(1);
    end

    // Sticky record that a divider sync has happened.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_synced <= 1'b0;
        else if (sync_rise) div_synced <= 1'b1;
    end

    // R1
    sync_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (cnt_q == '0));
    // R2
    en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && (mask != '0)) |=> (!data_en || (mask == '0)));
    // R6
    cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (aligned_cnt >= $past(aligned_cnt)));
endmodule

// File: rtl/strobe_detect.sv
// Module: strobe_detect
// Corrects the polarity of the transmit-enable line and samples it on
// data-rate enables. It flags the enable on which the line first moves into
// its asserted level.
// Assumes: the line meets setup and hold to the enable edges.
module strobe_detect
    import dac_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_en,
    input  logic txen_in,
    input  logic txen_invert,
    output logic strobe_hit
);
    strobe_pol_e pol;
    logic        lvl;
    logic        lvl_q;

    // Map the pin to "strobe asserted" according to the selected polarity.
    always_comb begin
        pol = strobe_pol_e'(txen_invert);
        lvl = (pol == STROBE_HIGH_GOING) ? txen_in : ~txen_in;
    end

    // Previous sampled level; starts as asserted so a stuck line is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= 1'b1;
        else if (data_en) lvl_q <= lvl;
    end

    assign strobe_hit = data_en & lvl & ~lvl_q;

    // R7
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> $stable(lvl_q));
endmodule

// File: rtl/nco_phase_acc.sv
// Module: nco_phase_acc
// Phase accumulator advancing by the tuning word on each data-rate enable.
// A detected strobe schedules a clear that takes effect on the next enable.
// Assumes: strobe_hit is only high together with data_en.
module nco_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_en,
    input  logic               strobe_hit,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase,
    output logic               nco_cleared
);
    logic pend_q;

    // Pending-clear flag loaded on every enable.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (data_en) pend_q <= strobe_hit;
    end

    // Accumulate or clear on enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (data_en) phase <= pend_q ? '0 : phase + ftw;
    end

    // Sticky record that a phase clear has happened.
    always_ff @(posedge clk) begin
        if (!rst_n)                 nco_cleared <= 1'b0;
        else if (data_en && pend_q) nco_cleared <= 1'b1;
    end

    // R8
    nco_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && pend_q) |=> (phase == '0));
    // R9
    nco_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> $stable(phase));
endmodule

// File: rtl/dac_sync_top.sv
// Module: dac_sync_top
// Two-step multi-device synchronizer: a fast-clock-sampled sync edge aligns
// the rate divider, then a data-rate strobe zeroes the NCO phase.
// Assumes: sync_in reaches every device within one fast-clock period.
module dac_sync_top #(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 4,
    parameter int SEL_W       = 3,
    parameter int ACNT_W      = 4,
    parameter int PHASE_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_in,
    input  logic               txen_in,
    input  logic               txen_invert,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic [PHASE_W-1:0] ftw,
    output logic               data_en,
    output logic [PHASE_W-1:0] nco_phase,
    output logic [ACNT_W-1:0]  aligned_cnt,
    output logic               sync_done
);
    logic sync_rise;
    logic div_synced;
    logic strobe_hit;
    logic nco_cleared;

    sync_rise_det #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sync_in),
        .rise_o   (sync_rise)
    );

    rate_divider #(.DIV_W(DIV_W), .SEL_W(SEL_W), .ACNT_W(ACNT_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_rise   (sync_rise),
        .div_sel     (div_sel),
        .data_en     (data_en),
        .div_synced  (div_synced),
        .aligned_cnt (aligned_cnt)
    );

    strobe_detect u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_en     (data_en),
        .txen_in     (txen_in),
        .txen_invert (txen_invert),
        .strobe_hit  (strobe_hit)
    );

    nco_phase_acc #(.PHASE_W(PHASE_W)) u_nco (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_en     (data_en),
        .strobe_hit  (strobe_hit),
        .ftw         (ftw),
        .phase       (nco_phase),
        .nco_cleared (nco_cleared)
    );

    // Both steps complete.
    assign sync_done = div_synced & nco_cleared;

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |=> sync_done);
endmodule

// File: tb/sim_dac_sync_top.sv
module sim_dac_sync_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_in = 1'b0;
    logic        txen_in = 1'b1;
    logic        txen_invert = 1'b0;
    logic [2:0]  div_sel = 3'd0;
    logic [15:0] ftw = 16'hF00D;
    logic        data_en;
    logic [15:0] nco_phase;
    logic [3:0]  aligned_cnt;
    logic        sync_done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    localparam int P = 64;
    localparam int Q = 2 * P + 5;

    always #4 clk = ~clk;

    dac_sync_top u0 (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .txen_in(txen_in),
        .txen_invert(txen_invert), .div_sel(div_sel), .ftw(ftw),
        .data_en(data_en), .nco_phase(nco_phase), .aligned_cnt(aligned_cnt),
        .sync_done(sync_done)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic next_en();
        @(negedge clk);
        while (!data_en) @(negedge clk);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        logic [15:0] p;
        // Divider sweep: one-shot, aligned periodic and misaligned sync (R1..R5, R12)
        for (int sel = 0; sel <= 4; sel++) begin
            int ratio;
            int base;
            logic [3:0] a0;
            logic [3:0] a1;
            ratio = 1 << sel;
            a0 = '0;
            a1 = '0;
            div_sel = 3'(sel);
            do_reset();
            check_eq("R12 phase", 32'(nco_phase), 32'h0);
            check_eq("R12 aligned_cnt", 32'(aligned_cnt), 32'h0);
            check_eq("R12 sync_done", 32'(sync_done), 32'h0);
            check_eq("R12 data_en", 32'(data_en), 32'(ratio == 1));
            sync_in = 1'b1;
            for (int t = 1; t <= Q + 3 + 2 * ratio; t++) begin
                @(negedge clk);
                if (t >= 3) begin
                    base = (t >= Q + 3) ? Q : 0;
                    if (t < P)
                        check_eq("R1 R2 R3 data_en", 32'(data_en), 32'(((t - 3 - base) % ratio) == ratio - 1));
                    else if (t < Q + 3)
                        check_eq("R4 data_en", 32'(data_en), 32'(((t - 3 - base) % ratio) == ratio - 1));
                    else
                        check_eq("R5 data_en", 32'(data_en), 32'(((t - 3 - base) % ratio) == ratio - 1));
                end
                if (t == P) a0 = aligned_cnt;
                if (t == Q) begin
                    check_eq("R4 aligned_cnt", 32'(aligned_cnt), 32'(a0 + 4'd1));
                    a1 = aligned_cnt;
                end
                sync_in = (t < 8) || (t >= P && t < P + 8) || (t >= Q && t < Q + 8);
            end
            check_eq("R5 aligned_cnt", 32'(aligned_cnt), 32'(a1 + ((ratio == 1) ? 4'd1 : 4'd0)));
        end

        // Saturation of the aligned counter (R6)
        div_sel = 3'd0;
        do_reset();
        repeat (20) begin
            sync_in = 1'b1;
            repeat (2) @(negedge clk);
            sync_in = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check_eq("R6 saturated", 32'(aligned_cnt), 32'd15);

        // Low-going strobe, accumulation and clear (R7..R10)
        div_sel = 3'd2;
        ftw = 16'hF00D;
        txen_invert = 1'b0;
        txen_in = 1'b1;
        do_reset();
        next_en();
        p = nco_phase;
        @(negedge clk);
        check_eq("R9 add", 32'(nco_phase), 32'(16'(p + ftw)));
        next_en();
        check_eq("R9 hold", 32'(nco_phase), 32'(16'(p + ftw)));
        txen_in = 1'b0;
        p = nco_phase;
        next_en();
        check_eq("R8 detect edge adds", 32'(nco_phase), 32'(16'(p + ftw)));
        @(negedge clk);
        check_eq("R8 cleared", 32'(nco_phase), 32'h0);
        check_eq("R11 no sync yet", 32'(sync_done), 32'h0);
        next_en();
        check_eq("R8 held zero", 32'(nco_phase), 32'h0);
        @(negedge clk);
        check_eq("R8 restart", 32'(nco_phase), 32'(ftw));
        repeat (3) begin
            next_en();
            p = nco_phase;
            @(negedge clk);
            check_eq("R10 held asserted", 32'(nco_phase), 32'(16'(p + ftw)));
        end
        txen_in = 1'b1;
        repeat (3) begin
            next_en();
            p = nco_phase;
            @(negedge clk);
            check_eq("R10 deassert edge", 32'(nco_phase), 32'(16'(p + ftw)));
        end

        // High-going strobe with line asserted at reset (R7, R10, R11)
        ftw = 16'h1234;
        txen_invert = 1'b1;
        txen_in = 1'b1;
        do_reset();
        repeat (3) begin
            next_en();
            p = nco_phase;
            @(negedge clk);
            check_eq("R7 asserted at reset", 32'(nco_phase), 32'(16'(p + ftw)));
        end
        txen_in = 1'b0;
        repeat (2) begin
            next_en();
            p = nco_phase;
            @(negedge clk);
            check_eq("R10 inverted deassert", 32'(nco_phase), 32'(16'(p + ftw)));
        end
        sync_in = 1'b1;
        repeat (4) @(negedge clk);
        sync_in = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R11 sync only", 32'(sync_done), 32'h0);
        next_en();
        txen_in = 1'b1;
        next_en();
        @(negedge clk);
        check_eq("R7 inverted clear", 32'(nco_phase), 32'h0);
        check_eq("R11 both done", 32'(sync_done), 32'h1);
        repeat (10) @(negedge clk);
        check_eq("R11 sticky", 32'(sync_done), 32'h1);
        do_reset();
        check_eq("R11 R12 reset clears", 32'(sync_done), 32'h0);

        finished = 1'b1;
        report();
    end
endmodule